// File: doc/BRIEF.md
# Password-Gated Banked Register Map

This block decodes every byte access coming from a register bus and decides whether it may reach the memory behind it, and where. The byte address space is split in two halves. The lower half (00h–7Fh) is always reachable. It holds three things that the block owns itself: a table-select byte, a four-byte password entry window, and the rest, which is passed through to memory. The upper half (80h–FFh) is banked. The table-select byte chooses which upper table appears there. Each table carries its own read and write privilege requirement.

Privilege comes from comparing the entry window against two stored four-byte passwords. The stored passwords sit inside the most protected table. A match with the higher password gives the top level, which includes everything the lower level may do. A match with the lower password gives the middle level. Anything else gives no privilege. The comparison is combinational, so any write that changes the entry window or a stored password takes effect on the next access.

A relocation bit moves the last eight bytes of the user table into an otherwise empty alternate table. While the bit is set, the user table reads those bytes as empty.

Accesses are sequenced by a small FSM with states ST_IDLE, ST_MEM_RD, ST_MEM_LATCH, ST_MEM_WR and ST_RESP:
- ST_IDLE moves to ST_MEM_RD on an accepted memory read.
- ST_IDLE moves to ST_MEM_WR on an accepted memory write.
- ST_IDLE moves to ST_RESP on any internal or blocked access.
- ST_MEM_RD moves to ST_MEM_LATCH.
- ST_MEM_LATCH moves to ST_RESP.
- ST_MEM_WR moves to ST_RESP.
- ST_RESP returns to ST_IDLE.

Top module: `pwgate_regmap`

## Requirements
- R1: Lower-half addresses other than the entry window (7Bh–7Eh) and the table-select byte (7Fh) are forwarded to memory with `mem_lower`=1, `mem_table`=0 and the unchanged address, at every privilege level.
- R2: The table-select byte at 7Fh resets to 00h and can be read and written at every privilege level.
- R3: Every entry-window byte resets to FFh. Writes to the window are always accepted. Reads of it always return 00h.
- R4: The level is HIGH when the window equals the high password, LOW when it equals only the low password, and NONE otherwise. Window byte 7Bh is compared with the most significant password byte. A window change that breaks a match lowers the level for the next access.
- R5: HIGH level grants every access that LOW level grants. An access is allowed when the level is at or above the table's requirement.
- R6: In table 2, offsets 80h–83h hold the low password and 84h–87h hold the high password, most significant byte first. They are read and written only at HIGH level.
- R7: A disallowed read returns FFh and causes no memory strobe. A disallowed write causes no memory strobe and changes no state.
- R8: The default table requirements (read/write) are: table 1: LOW/LOW; table 2: HIGH/HIGH; tables 4, 6 and 7: LOW/HIGH; table 5: LOW/LOW.
- R9: A selected table number that is not implemented (default set 1, 2, 4, 5, 6, 7) makes the upper half read FFh, ignore writes and strobe no memory.
- R10: Bit 0 of table 2 offset 88h is the relocation bit. When it is 0, table 5 is empty. When it is 1, table 5 offsets F8h–FFh reach memory table 1 at the same offsets under table 5's requirement, table 1 offsets F8h–FFh read FFh and ignore writes, and the rest of table 5 stays empty.
- R11: `req_valid` is taken when `req_ready` is high. `resp_valid` is a one-cycle pulse, 1 cycle after acceptance for internal or blocked accesses, 2 for memory writes and 3 for memory reads.
- R12: A memory read gives one `mem_en` pulse and returns the `mem_rdata` seen in the cycle after it. A memory write gives one `mem_we` pulse carrying the write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block idle, request taken |
| resp_valid | output | 1 | Access complete |
| resp_rdata | output | 8 | Read data (00h on writes) |
| mem_en | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_lower | output | 1 | Strobe targets the lower half |
| mem_table | output | 8 | Physical table of the strobe |
| mem_addr | output | 8 | Byte address of the strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_en` |

## Verification
The bench builds the block with two distinct passwords, A1B2C3D4h and 5E6F7081h, and keeps the default table set. This lets it walk all three levels. It drops a level by breaking one window byte, and it rewrites a stored password at HIGH level and then logs in with the new value. It exercises unimplemented selections (0, 3, 9, 12) and both settings of the relocation bit. Every access is compared on each clock against a behavioural model of latency, strobes, target table and data.

// File: rtl/pwgate_pkg.sv
package pwgate_pkg;

    typedef enum logic [1:0] {
        LV_NONE = 2'd0,
        LV_LOW  = 2'd1,
        LV_HIGH = 2'd2
    } level_e;

    typedef enum logic [2:0] {
        RT_MEM,
        RT_PWE,
        RT_TSEL,
        RT_PWSTORE,
        RT_CFG,
        RT_BLOCK
    } route_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEM_RD,
        ST_MEM_LATCH,
        ST_MEM_WR,
        ST_RESP
    } state_e;

endpackage

// File: rtl/pwgate_regs.sv
module pwgate_regs
    import pwgate_pkg::*;
#(
    parameter int                    PW_BYTES  = 4,
    parameter logic [8*PW_BYTES-1:0] PW1_INIT  = 32'h1357_9BDF,
    parameter logic [8*PW_BYTES-1:0] PW2_INIT  = 32'h2468_ACE0,
    parameter logic [7:0]            TSEL_INIT = 8'h00,
    localparam int                   IDX_W     = $clog2(2*PW_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  route_e           sel_route,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic [7:0]       wdata,
    output logic [7:0]       rd_data,
    output logic [7:0]       tsel,
    output logic             relocate,
    output level_e           level
);

    localparam int PI_W = $clog2(PW_BYTES);

    logic [7:0] pwe [PW_BYTES];
    logic [7:0] pw1 [PW_BYTES];
    logic [7:0] pw2 [PW_BYTES];
    logic [7:0] cfg;
    logic [7:0] tsel_q;
    logic       hit_low;
    logic       hit_high;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PW_BYTES; i++) begin
                pwe[i] <= 8'hFF;
                pw1[i] <= PW1_INIT[8*(PW_BYTES-1-i) +: 8];
                pw2[i] <= PW2_INIT[8*(PW_BYTES-1-i) +: 8];
            end
            cfg    <= 8'h00;
            tsel_q <= TSEL_INIT;
        end else if (wr_en) begin
            case (sel_route)
                RT_PWE:  pwe[sel_idx[PI_W-1:0]] <= wdata;
                RT_TSEL: tsel_q <= wdata;
                RT_CFG:  cfg <= wdata;
                RT_PWSTORE: begin
                    if (sel_idx[PI_W]) pw2[sel_idx[PI_W-1:0]] <= wdata;
                    else               pw1[sel_idx[PI_W-1:0]] <= wdata;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        hit_low  = 1'b1;
        hit_high = 1'b1;
        for (int i = 0; i < PW_BYTES; i++) begin
            if (pwe[i] != pw1[i]) hit_low  = 1'b0;
            if (pwe[i] != pw2[i]) hit_high = 1'b0;
        end
    end

    always_comb begin
        if (hit_high)     level = LV_HIGH;
        else if (hit_low) level = LV_LOW;
        else              level = LV_NONE;
    end

    always_comb begin
        case (sel_route)
            RT_PWE:     rd_data = 8'h00;
            RT_TSEL:    rd_data = tsel_q;
            RT_CFG:     rd_data = cfg;
            RT_PWSTORE: rd_data = sel_idx[PI_W] ? pw2[sel_idx[PI_W-1:0]]
                                                : pw1[sel_idx[PI_W-1:0]];
            default:    rd_data = 8'hFF;
        endcase
    end

    assign tsel     = tsel_q;
    assign relocate = cfg[0];

    AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(level)); // R4

    AST_TSEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tsel)); // R2

endmodule

// File: rtl/pwgate_decode.sv
module pwgate_decode
    import pwgate_pkg::*;
#(
    parameter int                    NUM_TBL     = 8,
    parameter logic [NUM_TBL-1:0]    TBL_PRESENT = 8'hF6,
    parameter logic [2*NUM_TBL-1:0]  TBL_RD_LVL  = 16'h5524,
    parameter logic [2*NUM_TBL-1:0]  TBL_WR_LVL  = 16'hA624,
    parameter int                    PW_BYTES    = 4,
    parameter logic [7:0]            PWE_BASE    = 8'h7B,
    parameter logic [7:0]            TSEL_ADDR   = 8'h7F,
    parameter int                    PW_TABLE    = 2,
    parameter logic [7:0]            PW_OFS      = 8'h80,
    parameter logic [7:0]            CFG_OFS     = 8'h88,
    parameter int                    HOME_TABLE  = 1,
    parameter int                    ALT_TABLE   = 5,
    parameter logic [7:0]            ALT_LO      = 8'hF8,
    localparam int                   IDX_W       = $clog2(2*PW_BYTES)
) (
    input  logic [7:0]       addr,
    input  logic             write,
    input  logic [7:0]       tsel,
    input  logic             relocate,
    input  level_e           level,
    output route_e           route,
    output logic [7:0]       table_id,
    output logic             lower,
    output logic [IDX_W-1:0] idx
);

    localparam int         TSEL_W   = $clog2(NUM_TBL);
    localparam logic [7:0] PWE_LAST = 8'(int'(PWE_BASE) + PW_BYTES - 1);
    localparam logic [7:0] PW_LAST  = 8'(int'(PW_OFS) + 2*PW_BYTES - 1);

    logic [TSEL_W-1:0] tidx;
    logic [1:0]        need;
    logic [1:0]        lv_bits;
    logic              in_range;
    logic              allowed;
    logic              usable;
    logic              in_alt;
    logic              is_pw_tbl;

    assign tidx      = tsel[TSEL_W-1:0];
    assign lv_bits   = level;
    assign in_range  = int'(tsel) < NUM_TBL;
    assign in_alt    = addr >= ALT_LO;
    assign is_pw_tbl = tsel == 8'(PW_TABLE);

    always_comb begin
        need = write ? TBL_WR_LVL[2*tidx +: 2] : TBL_RD_LVL[2*tidx +: 2];
        allowed = in_range && TBL_PRESENT[tidx] && (lv_bits >= need);
    end

    always_comb begin
        usable = 1'b1;
        if (tsel == 8'(ALT_TABLE)) begin
            usable = relocate && in_alt;
        end else if (tsel == 8'(HOME_TABLE)) begin
            usable = !(relocate && in_alt);
        end
    end

    always_comb begin
        route    = RT_BLOCK;
        table_id = tsel;
        lower    = 1'b0;
        idx      = '0;
        if (!addr[7]) begin
            lower    = 1'b1;
            table_id = 8'h00;
            if (addr >= PWE_BASE && addr <= PWE_LAST) begin
                route = RT_PWE;
                idx   = IDX_W'(addr - PWE_BASE);
            end else if (addr == TSEL_ADDR) begin
                route = RT_TSEL;
            end else begin
                route = RT_MEM;
            end
        end else begin
            if (tsel == 8'(ALT_TABLE)) table_id = 8'(HOME_TABLE);
            if (allowed && usable) begin
                if (is_pw_tbl && addr >= PW_OFS && addr <= PW_LAST) begin
                    route = RT_PWSTORE;
                    idx   = IDX_W'(addr - PW_OFS);
                end else if (is_pw_tbl && addr == CFG_OFS) begin
                    route = RT_CFG;
                end else begin
                    route = RT_MEM;
                end
            end
        end
    end

endmodule

// File: rtl/pwgate_regmap.sv
module pwgate_regmap
    import pwgate_pkg::*;
#(
    parameter int                    NUM_TBL     = 8,
    parameter logic [NUM_TBL-1:0]    TBL_PRESENT = 8'hF6,
    parameter logic [2*NUM_TBL-1:0]  TBL_RD_LVL  = 16'h5524,
    parameter logic [2*NUM_TBL-1:0]  TBL_WR_LVL  = 16'hA624,
    parameter int                    PW_BYTES    = 4,
    parameter logic [8*PW_BYTES-1:0] PW1_INIT    = 32'h1357_9BDF,
    parameter logic [8*PW_BYTES-1:0] PW2_INIT    = 32'h2468_ACE0,
    parameter logic [7:0]            TSEL_INIT   = 8'h00,
    parameter logic [7:0]            PWE_BASE    = 8'h7B,
    parameter logic [7:0]            TSEL_ADDR   = 8'h7F,
    parameter int                    PW_TABLE    = 2,
    parameter logic [7:0]            PW_OFS      = 8'h80,
    parameter logic [7:0]            CFG_OFS     = 8'h88,
    parameter int                    HOME_TABLE  = 1,
    parameter int                    ALT_TABLE   = 5,
    parameter logic [7:0]            ALT_LO      = 8'hF8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [7:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic       req_ready,
    output logic       resp_valid,
    output logic [7:0] resp_rdata,
    output logic       mem_en,
    output logic       mem_we,
    output logic       mem_lower,
    output logic [7:0] mem_table,
    output logic [7:0] mem_addr,
    output logic [7:0] mem_wdata,
    input  logic [7:0] mem_rdata
);

    localparam int IDX_W  = $clog2(2*PW_BYTES);
    localparam int TSEL_W = $clog2(NUM_TBL);

    state_e           state_q, state_d;
    route_e           dec_route;
    logic [7:0]       dec_table;
    logic             dec_lower;
    logic [IDX_W-1:0] dec_idx;
    logic [7:0]       tsel;
    logic             relocate;
    level_e           level;
    logic [7:0]       reg_rd;
    logic             accept;
    logic             reg_wr;

    route_e           tx_route;
    logic             tx_rd;
    logic [7:0]       tx_table;
    logic             tx_lower;
    logic [7:0]       tx_addr;
    logic [7:0]       tx_wdata;
    logic [7:0]       rdata_q;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign reg_wr = accept && req_write &&
                    (dec_route inside {RT_PWE, RT_TSEL, RT_PWSTORE, RT_CFG});

    pwgate_decode #(
        .NUM_TBL    (NUM_TBL),
        .TBL_PRESENT(TBL_PRESENT),
        .TBL_RD_LVL (TBL_RD_LVL),
        .TBL_WR_LVL (TBL_WR_LVL),
        .PW_BYTES   (PW_BYTES),
        .PWE_BASE   (PWE_BASE),
        .TSEL_ADDR  (TSEL_ADDR),
        .PW_TABLE   (PW_TABLE),
        .PW_OFS     (PW_OFS),
        .CFG_OFS    (CFG_OFS),
        .HOME_TABLE (HOME_TABLE),
        .ALT_TABLE  (ALT_TABLE),
        .ALT_LO     (ALT_LO)
    ) u_decode (
        .addr    (req_addr),
        .write   (req_write),
        .tsel    (tsel),
        .relocate(relocate),
        .level   (level),
        .route   (dec_route),
        .table_id(dec_table),
        .lower   (dec_lower),
        .idx     (dec_idx)
    );

    pwgate_regs #(
        .PW_BYTES (PW_BYTES),
        .PW1_INIT (PW1_INIT),
        .PW2_INIT (PW2_INIT),
        .TSEL_INIT(TSEL_INIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel_route(dec_route),
        .sel_idx  (dec_idx),
        .wdata    (req_wdata),
        .rd_data  (reg_rd),
        .tsel     (tsel),
        .relocate (relocate),
        .level    (level)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (dec_route == RT_MEM) state_d = req_write ? ST_MEM_WR : ST_MEM_RD;
                    else                     state_d = ST_RESP;
                end
            end
            ST_MEM_RD:    state_d = ST_MEM_LATCH;
            ST_MEM_LATCH: state_d = ST_RESP;
            ST_MEM_WR:    state_d = ST_RESP;
            ST_RESP:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        mem_en     = (state_q == ST_MEM_RD);
        mem_we     = (state_q == ST_MEM_WR);
        resp_valid = (state_q == ST_RESP);
        resp_rdata = rdata_q;
        mem_lower  = tx_lower;
        mem_table  = tx_table;
        mem_addr   = tx_addr;
        mem_wdata  = tx_wdata;
    end

    // transaction capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_route <= RT_BLOCK;
            tx_rd    <= 1'b0;
            tx_table <= 8'h00;
            tx_lower <= 1'b0;
            tx_addr  <= 8'h00;
            tx_wdata <= 8'h00;
            rdata_q  <= 8'h00;
        end else if (accept) begin
            tx_route <= dec_route;
            tx_rd    <= !req_write;
            tx_table <= dec_table;
            tx_lower <= dec_lower;
            tx_addr  <= req_addr;
            tx_wdata <= req_wdata;
            rdata_q  <= req_write ? 8'h00 : reg_rd;
        end else if (state_q == ST_MEM_LATCH) begin
            rdata_q  <= mem_rdata;
        end
    end

    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R11

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en && !mem_we); // R12

    AST_MEM_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en || mem_we) && !mem_lower |->
        (int'(mem_table) < NUM_TBL) && TBL_PRESENT[mem_table[TSEL_W-1:0]]); // R9

    AST_PW_TABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en || mem_we) && !mem_lower && (mem_table == 8'(PW_TABLE)) |->
        level == LV_HIGH); // R8

    AST_PWE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && tx_rd && (tx_route == RT_PWE) |-> resp_rdata == 8'h00); // R3

    AST_BLOCK_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && tx_rd && (tx_route == RT_BLOCK) |-> resp_rdata == 8'hFF); // R7

endmodule

// File: tb/pwgate_regmap_tb.sv
module pwgate_regmap_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid, req_write;
    logic [7:0] req_addr, req_wdata;
    logic       req_ready, resp_valid;
    logic [7:0] resp_rdata;
    logic       mem_en, mem_we, mem_lower;
    logic [7:0] mem_table, mem_addr, mem_wdata;
    logic [7:0] mem_rdata;

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0] bmem [0:8][0:255];
    logic [7:0] m_pwe [4];
    logic [7:0] m_pw1 [4];
    logic [7:0] m_pw2 [4];
    logic [7:0] m_tsel;
    logic [7:0] m_cfg;

    pwgate_regmap #(
        .PW1_INIT(32'hA1B2_C3D4),
        .PW2_INIT(32'h5E6F_7081)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_lower(mem_lower),
        .mem_table(mem_table), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // memory behind the block: one cycle read latency
    always @(posedge clk) begin
        int ti;
        ti = mem_lower ? 8 : ((mem_table > 8'd7) ? 0 : int'(mem_table));
        if (mem_en) mem_rdata <= bmem[ti][mem_addr];
        if (mem_we) bmem[ti][mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int m_level();
        bit h1, h2;
        h1 = 1; h2 = 1;
        for (int i = 0; i < 4; i++) begin
            if (m_pwe[i] != m_pw1[i]) h1 = 0;
            if (m_pwe[i] != m_pw2[i]) h2 = 0;
        end
        return h2 ? 2 : (h1 ? 1 : 0);
    endfunction

    // 0 lower mem, 1 window, 2 select, 3 stored pw, 4 cfg, 5 blocked, 6 upper mem
    function automatic int m_route(input int a, input bit w, output int ptab);
        int t, need, lv;
        ptab = 0;
        if (a < 128) begin
            if (a >= 'h7B && a <= 'h7E) return 1;
            if (a == 'h7F) return 2;
            ptab = 8;
            return 0;
        end
        t  = int'(m_tsel);
        lv = m_level();
        if (!(t == 1 || t == 2 || t == 4 || t == 5 || t == 6 || t == 7)) return 5;
        if (t == 1 || t == 5) need = 1;
        else if (t == 2)      need = 2;
        else                  need = w ? 2 : 1;
        if (lv < need) return 5;
        if (t == 5) begin
            if (m_cfg[0] && a >= 'hF8) ptab = 1;
            else return 5;
        end else if (t == 1 && m_cfg[0] && a >= 'hF8) begin
            return 5;
        end else begin
            ptab = t;
        end
        if (t == 2 && a >= 'h80 && a <= 'h87) return 3;
        if (t == 2 && a == 'h88) return 4;
        return 6;
    endfunction

    task automatic access(input bit w, input logic [7:0] a, input logic [7:0] d,
                          input string req);
        int ptab, rt, exp_lat, lat, nstr, exp_str;
        logic [7:0] exp_rd, s_tab, s_addr, s_wd;
        bit s_low;
        rt = m_route(int'(a), w, ptab);
        exp_str = (rt == 0 || rt == 6) ? 1 : 0;
        exp_lat = exp_str ? (w ? 2 : 3) : 1;
        case (rt)
            0, 6:    exp_rd = bmem[ptab][a];
            1:       exp_rd = 8'h00;
            2:       exp_rd = m_tsel;
            3:       exp_rd = (a >= 8'h84) ? m_pw2[int'(a) - 'h84] : m_pw1[int'(a) - 'h80];
            4:       exp_rd = m_cfg;
            default: exp_rd = 8'hFF;
        endcase
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        lat = 1; nstr = 0; s_tab = 0; s_addr = 0; s_wd = 0; s_low = 0;
        while (1) begin
            if (mem_en || mem_we) begin
                nstr++;
                s_tab = mem_table; s_addr = mem_addr; s_low = mem_lower; s_wd = mem_wdata;
                if (mem_we != w) nstr += 10;
            end
            if (resp_valid || lat > 8) break;
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, req, $sformatf("latency addr %0h", a), lat, exp_lat);
        chk(nstr == exp_str, req, $sformatf("memory strobes addr %0h", a), nstr, exp_str);
        if (exp_str == 1 && nstr == 1) begin
            chk(s_low == (rt == 0), req, "strobe region", s_low, rt == 0);
            chk(s_tab == ((rt == 6) ? 8'(ptab) : 8'h00), req, "strobe table", s_tab,
                (rt == 6) ? ptab : 0);
            chk(s_addr == a, req, "strobe address", s_addr, a);
            if (w) chk(s_wd == d, req, "strobe write data", s_wd, d);
        end
        if (!w) chk(resp_rdata == exp_rd, req, $sformatf("read data addr %0h", a),
                    resp_rdata, exp_rd);
        @(negedge clk);
        chk(!resp_valid, "R11", "response longer than one cycle", resp_valid, 0);
        if (w) begin
            case (rt)
                1: m_pwe[int'(a) - 'h7B] = d;
                2: m_tsel = d;
                3: if (a >= 8'h84) m_pw2[int'(a) - 'h84] = d; else m_pw1[int'(a) - 'h80] = d;
                4: m_cfg = d;
                default: ;
            endcase
        end
    endtask

    task automatic enter_pw(input logic [31:0] v, input string req);
        for (int i = 0; i < 4; i++) access(1, 8'(8'h7B + i), v[8*(3-i) +: 8], req);
    endtask

    initial begin
        #800000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < 9; t++)
            for (int a = 0; a < 256; a++) bmem[t][a] = 8'(t * 37 + a * 5 + 3);
        for (int i = 0; i < 4; i++) m_pwe[i] = 8'hFF;
        m_pw1 = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
        m_pw2 = '{8'h5E, 8'h6F, 8'h70, 8'h81};
        m_tsel = 8'h00; m_cfg = 8'h00;
        req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !resp_valid && !mem_en && !mem_we, "R11", "reset outputs",
            {req_ready, resp_valid, mem_en, mem_we}, 4'b1000);

        // lower half, window, select
        access(0, 8'h7B, 0, "R3");
        access(0, 8'h7F, 0, "R2");
        access(0, 8'h10, 0, "R1");
        access(1, 8'h20, 8'h5A, "R1");
        access(0, 8'h20, 0, "R12");
        // unimplemented selections
        access(0, 8'h90, 0, "R9");
        access(1, 8'h7F, 8'h03, "R2");
        access(0, 8'h7F, 0, "R2");
        access(0, 8'hA0, 0, "R9");
        access(1, 8'hA0, 8'h77, "R9");
        access(1, 8'h7F, 8'h09, "R9");
        access(0, 8'h80, 0, "R9");
        access(1, 8'h7F, 8'h0C, "R9");
        access(1, 8'hC0, 8'h11, "R9");
        // no privilege
        access(1, 8'h7F, 8'h01, "R2");
        access(0, 8'h80, 0, "R7");
        access(1, 8'h80, 8'h33, "R7");
        // low level
        enter_pw(32'hA1B2_C3D4, "R4");
        access(0, 8'h7C, 0, "R3");
        access(0, 8'h80, 0, "R4");
        access(1, 8'h81, 8'h44, "R8");
        access(0, 8'h81, 0, "R8");
        access(1, 8'h7F, 8'h02, "R2");
        access(0, 8'h80, 0, "R6");
        access(1, 8'h84, 8'h00, "R6");
        access(1, 8'h7F, 8'h04, "R2");
        access(0, 8'h90, 0, "R8");
        access(1, 8'h90, 8'h12, "R8");
        access(0, 8'h90, 0, "R7");
        // break one byte: level drops
        access(1, 8'h7E, 8'h00, "R4");
        access(0, 8'h90, 0, "R4");
        // high level
        enter_pw(32'h5E6F_7081, "R4");
        access(1, 8'h90, 8'h12, "R5");
        access(0, 8'h90, 0, "R5");
        access(1, 8'h7F, 8'h02, "R2");
        access(0, 8'h80, 0, "R6");
        access(0, 8'h84, 0, "R6");
        access(0, 8'h87, 0, "R6");
        access(0, 8'h8A, 0, "R8");
        access(1, 8'h7F, 8'h01, "R2");
        access(1, 8'hF9, 8'h66, "R5");
        access(0, 8'hF9, 0, "R5");
        // relocation
        access(1, 8'h7F, 8'h05, "R2");
        access(0, 8'hF8, 0, "R10");
        access(0, 8'h90, 0, "R10");
        access(1, 8'h7F, 8'h02, "R2");
        access(1, 8'h88, 8'h01, "R10");
        access(0, 8'h88, 0, "R10");
        access(1, 8'h7F, 8'h05, "R2");
        access(0, 8'hF9, 0, "R10");
        access(1, 8'hFA, 8'h99, "R10");
        access(0, 8'hFA, 0, "R10");
        access(0, 8'hF0, 0, "R10");
        access(1, 8'h7F, 8'h01, "R2");
        access(0, 8'hFA, 0, "R10");
        access(1, 8'hFB, 8'h21, "R10");
        access(0, 8'hF0, 0, "R10");
        // rewrite the low password, then use it
        access(1, 8'h7F, 8'h02, "R2");
        access(1, 8'h80, 8'h11, "R6");
        access(1, 8'h81, 8'h22, "R6");
        access(1, 8'h82, 8'h33, "R6");
        access(1, 8'h83, 8'h44, "R6");
        access(0, 8'h81, 0, "R6");
        enter_pw(32'h1122_3344, "R4");
        access(0, 8'h80, 0, "R6");
        access(1, 8'h83, 8'h00, "R6");
        access(1, 8'h7F, 8'h01, "R2");
        access(0, 8'h85, 0, "R5");
        // drop to no privilege
        access(1, 8'h7B, 8'h00, "R4");
        access(0, 8'h85, 0, "R4");
        access(0, 8'h7D, 0, "R3");
        access(0, 8'h30, 0, "R1");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule